// File: doc/BRIEF.md
# SPI Interrupt and FIFO Status Unit

This block holds the interrupt and status logic of an SPI port controller. It takes event strobes from the serial shifter and from the transmit and receive FIFOs, and it keeps one interrupt flag per event source. It also keeps a sticky FIFO error bit and a three-bit enable mask, and drives a single combined interrupt line. A small receive assembler is included. It collects serial bits most-significant first and reports a received word once the programmed number of bits has arrived. That number is either a whole byte or a partial count of one to seven bits.

Software uses a simple register port with a write strobe and a combinational read mux, and can reach three registers. The control register (address 0) holds the receive length code and a write-only FIFO init bit. The enable register (address 1) holds the interrupt mask. The status register (address 2) holds the flags and the error bit. Interrupt flags are cleared by writing ones to the status register. The error bit is cleared only by a FIFO init command. Whether the error bit means a transmit underflow or a receive overflow is decided by software, which reads it together with the FIFO empty and full indications.

Top module: `spi_irq_status`

## Requirements
- R1: After reset, all three registers read 0 and `irq` is 0; address 3 always reads 0.
- R2: With length code 0 (control bits 2:0), `rx_word_valid` pulses for one cycle, one clock after the eighth `bit_valid` sample. `rx_word` then holds the eight bits, with the first received bit as bit 7.
- R3: With length code N from 1 to 7, `rx_word_valid` pulses one clock after the Nth bit sample. `rx_word` holds those N bits right-aligned, with the first bit as bit N-1 and all higher bits 0.
- R4: The enable register keeps write data bits 2 (receive), 1 (transmit) and 0 (transfer). All its other bits read 0. The control register reads back only its length code in bits 2:0.
- R5: Status bit 2 sets on a completed receive word, bit 1 on `tx_byte_done`, and bit 0 on `blk_done`. Each sets whether or not its enable bit is 1.
- R6: Writing a 1 to status bit 0, 1 or 2 clears that flag, and writing a 0 leaves it as it was. If a clear and a new event for the same flag fall in one cycle, the flag remains set.
- R7: `irq` is 1 exactly when some status flag in bits 2:0 is set and its enable bit at the same position is 1.
- R8: Status bit 7 (FIFO error) sets on a `fifo_pop` while `tx_empty` is 1, or on a `fifo_push` while `rx_full` is 1. A push or pop at any other time leaves it unchanged.
- R9: The FIFO error bit stays set until a write of 1 to control bit 3 (FIFO init). Writing 1 to status bit 7 has no effect on it. An error event in the same cycle as FIFO init leaves the bit set.
- R10: Control bit 3 is not stored and reads 0. The FIFO error bit does not affect `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address (0 control, 1 enable, 2 status) |
| wr_data | input | 16 | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | 16 | Combinational read data |
| bit_valid | input | 1 | A received serial bit is present on `bit_in` |
| bit_in | input | 1 | Received serial bit, first bit most significant |
| tx_byte_done | input | 1 | Transmit byte completed strobe |
| blk_done | input | 1 | Block transfer completed strobe |
| fifo_push | input | 1 | Receive FIFO push strobe |
| fifo_pop | input | 1 | Transmit FIFO pop strobe |
| tx_empty | input | 1 | Transmit FIFO is empty |
| rx_full | input | 1 | Receive FIFO is full |
| rx_word | output | 8 | Last completed received word, right-aligned |
| rx_word_valid | output | 1 | One-cycle pulse when `rx_word` is updated |
| irq | output | 1 | Combined interrupt request |

## Verification
Two functions can collide in one clock. A software clear of a flag can land in the same cycle as the event that sets that flag. A FIFO init command can land in the same cycle as a new underflow or overflow. The bench provokes each collision by driving the register write and the event strobe on the same falling edge. It then reads the status register one cycle later. A correct design must show the flag, or the error bit, still set. A separate read after a clear or init with no event present confirms that the bit does drop when nothing competes with the clear.

// File: rtl/spi_irq_pkg.sv
package spi_irq_pkg;
  localparam int RX_W   = 8;
  localparam int LEN_W  = 3;
  localparam int CNT_W  = $clog2(RX_W + 1);
  localparam int NSRC   = 3;
  localparam int REG_W  = 16;
  localparam int ADDR_W = 2;

  // Flag and enable bit positions; software decodes these.
  localparam int SRC_XFR = 0;
  localparam int SRC_TX  = 1;
  localparam int SRC_RX  = 2;
  localparam int ERR_POS  = 7;
  localparam int INIT_POS = 3;

  typedef enum logic [ADDR_W-1:0] {
    REG_CTRL = 2'd0,
    REG_IEN  = 2'd1,
    REG_STAT = 2'd2,
    REG_NONE = 2'd3
  } reg_sel_e;

  // Number of bits in one receive frame for a length code.
  function automatic logic [CNT_W-1:0] frame_bits(input logic [LEN_W-1:0] code);
    frame_bits = (code == '0) ? CNT_W'(RX_W) : CNT_W'(code);
  endfunction

  // Mask keeping the low frame_bits(code) bits of a word.
  function automatic logic [RX_W-1:0] keep_mask(input logic [LEN_W-1:0] code);
    logic [RX_W-1:0] m;
    for (int i = 0; i < RX_W; i++) m[i] = (i < int'(frame_bits(code)));
    return m;
  endfunction
endpackage

// File: rtl/spi_rx_assembler.sv
module spi_rx_assembler
  import spi_irq_pkg::*;
#(
  parameter int W  = RX_W,
  parameter int LW = LEN_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [LW-1:0] len_code,
  input  logic          bit_valid,
  input  logic          bit_in,
  output logic [W-1:0]  word,
  output logic          done
);
  localparam int CW = $clog2(W + 1);

  logic [W-1:0]  shreg;
  logic [CW-1:0] cnt;
  logic [W-1:0]  shifted;
  logic          last_bit;
  logic [CW:0]   need;

  assign shifted  = {shreg[W-2:0], bit_in};
  assign need     = (CW+1)'(frame_bits(len_code));
  assign last_bit = bit_valid && (({1'b0, cnt} + 1'b1) >= need);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shreg <= '0;
      cnt   <= '0;
      word  <= '0;
      done  <= 1'b0;
    end else begin
      done <= last_bit;
      if (bit_valid) begin
        if (last_bit) begin
          word  <= shifted & keep_mask(len_code);
          shreg <= '0;
          cnt   <= '0;
        end else begin
          shreg <= shifted;
          cnt   <= cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/spi_int_flags.sv
module spi_int_flags
  import spi_irq_pkg::*;
#(
  parameter int N = NSRC
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] evt,
  input  logic [N-1:0] clr,
  input  logic [N-1:0] en,
  input  logic         fifo_push,
  input  logic         fifo_pop,
  input  logic         tx_empty,
  input  logic         rx_full,
  input  logic         fifo_init,
  output logic [N-1:0] flags,
  output logic         err,
  output logic         err_evt,
  output logic         irq
);
  assign err_evt = (fifo_pop && tx_empty) || (fifo_push && rx_full);

  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rst_n) flags[i] <= 1'b0;
      else        flags[i] <= evt[i] | (flags[i] & ~clr[i]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) err <= 1'b0;
    else        err <= err_evt | (err & ~fifo_init);
  end

  assign irq = |(flags & en);
endmodule

// File: rtl/spi_irq_status.sv
module spi_irq_status
  import spi_irq_pkg::*;
#(
  parameter int DW = REG_W,
  parameter int AW = ADDR_W,
  parameter int WW = RX_W,
  parameter int LW = LEN_W,
  parameter int NS = NSRC
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  input  logic          bit_valid,
  input  logic          bit_in,
  input  logic          tx_byte_done,
  input  logic          blk_done,
  input  logic          fifo_push,
  input  logic          fifo_pop,
  input  logic          tx_empty,
  input  logic          rx_full,
  output logic [WW-1:0] rx_word,
  output logic          rx_word_valid,
  output logic          irq
);
  logic [LW-1:0] len_q;
  logic [NS-1:0] en_q;
  logic          wr_ctrl, wr_ien, wr_stat;
  logic          fifo_init;
  logic [NS-1:0] clr_vec;
  logic [NS-1:0] evt_vec;
  logic [NS-1:0] flags;
  logic          err;
  logic          err_evt;
  logic          rx_evt;

  assign wr_ctrl   = wr_en && (wr_addr == REG_CTRL);
  assign wr_ien    = wr_en && (wr_addr == REG_IEN);
  assign wr_stat   = wr_en && (wr_addr == REG_STAT);
  assign fifo_init = wr_ctrl && wr_data[INIT_POS];
  assign clr_vec   = wr_stat ? wr_data[NS-1:0] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      len_q <= '0;
      en_q  <= '0;
    end else begin
      if (wr_ctrl) len_q <= wr_data[LW-1:0];
      if (wr_ien)  en_q  <= wr_data[NS-1:0];
    end
  end

  spi_rx_assembler #(.W(WW), .LW(LW)) u_rx (
    .clk(clk), .rst_n(rst_n), .len_code(len_q),
    .bit_valid(bit_valid), .bit_in(bit_in),
    .word(rx_word), .done(rx_evt)
  );
  assign rx_word_valid = rx_evt;

  always_comb begin
    evt_vec          = '0;
    evt_vec[SRC_RX]  = rx_evt;
    evt_vec[SRC_TX]  = tx_byte_done;
    evt_vec[SRC_XFR] = blk_done;
  end

  spi_int_flags #(.N(NS)) u_flags (
    .clk(clk), .rst_n(rst_n), .evt(evt_vec), .clr(clr_vec), .en(en_q),
    .fifo_push(fifo_push), .fifo_pop(fifo_pop), .tx_empty(tx_empty),
    .rx_full(rx_full), .fifo_init(fifo_init),
    .flags(flags), .err(err), .err_evt(err_evt), .irq(irq)
  );

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      REG_CTRL: rd_data[LW-1:0] = len_q;
      REG_IEN:  rd_data[NS-1:0] = en_q;
      REG_STAT: begin
        rd_data[NS-1:0]  = flags;
        rd_data[ERR_POS] = err;
      end
      default:  rd_data = '0;
    endcase
  end
endmodule

// File: rtl/spi_irq_status_chk.sv
module spi_irq_status_chk
  import spi_irq_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic [NSRC-1:0] flags,
  input logic [NSRC-1:0] en_q,
  input logic [NSRC-1:0] clr_vec,
  input logic            err,
  input logic            err_evt,
  input logic            fifo_init,
  input logic            irq,
  input logic            rx_evt,
  input logic            tx_byte_done,
  input logic            blk_done,
  input logic [RX_W-1:0] rx_word,
  input logic [LEN_W-1:0] len_q
);
  a_r5_rx_sets: assert property (@(posedge clk) disable iff (!rst_n)
    rx_evt |=> flags[SRC_RX]);
  a_r5_tx_sets: assert property (@(posedge clk) disable iff (!rst_n)
    tx_byte_done |=> flags[SRC_TX]);
  a_r5_xfr_sets: assert property (@(posedge clk) disable iff (!rst_n)
    blk_done |=> flags[SRC_XFR]);
  a_r6_tx_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_vec[SRC_TX] && !tx_byte_done) |=> !flags[SRC_TX]);
  a_r7_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q == '0) |-> !irq);
  a_r7_no_flag_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (flags == '0) |-> !irq);
  a_r8_err_sets: assert property (@(posedge clk) disable iff (!rst_n)
    err_evt |=> err);
  a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (err && !fifo_init) |=> err);
  a_r9_err_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_init && !err_evt) |=> !err);
  a_r3_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rx_evt |-> ((rx_word & ~keep_mask(len_q)) == '0));
endmodule

bind spi_irq_status spi_irq_status_chk u_chk (
  .clk(clk), .rst_n(rst_n), .flags(flags), .en_q(en_q), .clr_vec(clr_vec),
  .err(err), .err_evt(err_evt), .fifo_init(fifo_init), .irq(irq),
  .rx_evt(rx_evt), .tx_byte_done(tx_byte_done), .blk_done(blk_done),
  .rx_word(rx_word), .len_q(len_q)
);

// File: tb/spi_irq_status_bench.sv
module spi_irq_status_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [1:0]  wr_addr;
  logic [15:0] wr_data;
  logic [1:0]  rd_addr;
  logic [15:0] rd_data;
  logic        bit_valid, bit_in;
  logic        tx_byte_done, blk_done;
  logic        fifo_push, fifo_pop, tx_empty, rx_full;
  logic [7:0]  rx_word;
  logic        rx_word_valid;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done_flag = 1'b0;

  always #10 clk = ~clk;

  spi_irq_status u_spi_irq_status (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .bit_valid(bit_valid), .bit_in(bit_in), .tx_byte_done(tx_byte_done),
    .blk_done(blk_done), .fifo_push(fifo_push), .fifo_pop(fifo_pop),
    .tx_empty(tx_empty), .rx_full(rx_full), .rx_word(rx_word),
    .rx_word_valid(rx_word_valid), .irq(irq)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic rd_check(input string req, input logic [1:0] a, input logic [15:0] exp);
    rd_addr = a;
    #1;
    check(req, rd_data, exp);
  endtask

  // Sends n bits of val, most significant of the n first; checks the valid pulse timing.
  task automatic send_bits(input string req, input int n, input logic [7:0] val);
    for (int i = n - 1; i >= 0; i--) begin
      @(negedge clk);
      #1;
      if (i != n - 1) check({req, " no early valid"}, 16'(rx_word_valid), 16'h0);
      bit_valid = 1'b1; bit_in = val[i];
    end
    @(negedge clk);
    bit_valid = 1'b0;
    #1;
    check({req, " valid pulse"}, 16'(rx_word_valid), 16'h1);
    check({req, " word"}, 16'(rx_word), 16'(val));
    @(negedge clk);
    #1;
    check({req, " single pulse"}, 16'(rx_word_valid), 16'h0);
  endtask

  task automatic t_reset;
    rd_check("R1 ctrl", 2'd0, 16'h0);
    rd_check("R1 ien", 2'd1, 16'h0);
    rd_check("R1 stat", 2'd2, 16'h0);
    rd_check("R1 addr3", 2'd3, 16'h0);
    check("R1 irq", 16'(irq), 16'h0);
  endtask

  task automatic t_full_byte;
    wr(2'd0, 16'h0000);
    send_bits("R2 full byte", 8, 8'hA5);
    rd_check("R5 rx flag", 2'd2, 16'h0004);
    send_bits("R2 full byte 2", 8, 8'h3C);
    wr(2'd2, 16'h0007);
    rd_check("R6 cleared", 2'd2, 16'h0000);
  endtask

  task automatic t_partial;
    wr(2'd0, 16'h0003);
    rd_check("R4 ctrl readback", 2'd0, 16'h0003);
    send_bits("R3 len3", 3, 8'h05);
    wr(2'd0, 16'h0007);
    send_bits("R3 len7", 7, 8'h7F);
    wr(2'd0, 16'h0001);
    send_bits("R3 len1", 1, 8'h01);
    wr(2'd0, 16'hFFF0);
    rd_check("R10 ctrl init bit reads 0", 2'd0, 16'h0000);
    wr(2'd2, 16'h0007);
  endtask

  task automatic t_enable_irq;
    wr(2'd1, 16'hFFF8);
    rd_check("R4 ien reserved", 2'd1, 16'h0000);
    @(negedge clk); tx_byte_done = 1'b1; blk_done = 1'b1;
    @(negedge clk); tx_byte_done = 1'b0; blk_done = 1'b0;
    #1;
    rd_check("R5 flags while disabled", 2'd2, 16'h0003);
    check("R7 irq masked", 16'(irq), 16'h0);
    wr(2'd1, 16'h0004);
    #1;
    check("R7 irq other enable", 16'(irq), 16'h0);
    wr(2'd1, 16'h0001);
    rd_check("R4 ien readback", 2'd1, 16'h0001);
    check("R7 irq xfr", 16'(irq), 16'h1);
    wr(2'd2, 16'h0001);
    #1;
    check("R7 irq after clear", 16'(irq), 16'h0);
    rd_check("R6 write zero keeps tx", 2'd2, 16'h0002);
    wr(2'd1, 16'h0002);
    #1;
    check("R7 irq tx", 16'(irq), 16'h1);
  endtask

  task automatic t_clear_collide;
    @(negedge clk);
    tx_byte_done = 1'b1; wr_en = 1'b1; wr_addr = 2'd2; wr_data = 16'h0002;
    @(negedge clk);
    tx_byte_done = 1'b0; wr_en = 1'b0; wr_data = '0;
    rd_check("R6 event wins over clear", 2'd2, 16'h0002);
    wr(2'd2, 16'h0002);
    rd_check("R6 clear alone", 2'd2, 16'h0000);
    wr(2'd1, 16'h0000);
  endtask

  task automatic t_fifo_err;
    @(negedge clk); fifo_push = 1'b1; fifo_pop = 1'b1;
    @(negedge clk); fifo_push = 1'b0; fifo_pop = 1'b0;
    rd_check("R8 no error when not empty/full", 2'd2, 16'h0000);
    @(negedge clk); fifo_pop = 1'b1; tx_empty = 1'b1;
    @(negedge clk); fifo_pop = 1'b0; tx_empty = 1'b0;
    rd_check("R8 underflow", 2'd2, 16'h0080);
    wr(2'd1, 16'h0007);
    #1;
    check("R10 err no irq", 16'(irq), 16'h0);
    wr(2'd2, 16'h0080);
    rd_check("R9 w1c ignored", 2'd2, 16'h0080);
    wr(2'd0, 16'h0008);
    rd_check("R9 init clears", 2'd2, 16'h0000);
    rd_check("R10 init not stored", 2'd0, 16'h0000);
    @(negedge clk); fifo_push = 1'b1; rx_full = 1'b1;
    @(negedge clk); fifo_push = 1'b0; rx_full = 1'b0;
    rd_check("R8 overflow", 2'd2, 16'h0080);
    @(negedge clk);
    fifo_push = 1'b1; rx_full = 1'b1; wr_en = 1'b1; wr_addr = 2'd0; wr_data = 16'h0008;
    @(negedge clk);
    fifo_push = 1'b0; rx_full = 1'b0; wr_en = 1'b0; wr_data = '0;
    rd_check("R9 error wins over init", 2'd2, 16'h0080);
    wr(2'd0, 16'h0008);
    rd_check("R9 init clears again", 2'd2, 16'h0000);
  endtask

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0;
    bit_valid = 1'b0; bit_in = 1'b0; tx_byte_done = 1'b0; blk_done = 1'b0;
    fifo_push = 1'b0; fifo_pop = 1'b0; tx_empty = 1'b0; rx_full = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_full_byte();
    t_partial();
    t_enable_irq();
    t_clear_collide();
    t_fifo_err();
    done_flag = 1'b1;
  end

  initial begin
    fork
      wait (done_flag);
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule